// File: doc/BRIEF.md
# Command Frame Byte Serializer

This block packs an 8-bit blink pattern and a 32-bit period into a fixed eight-byte command frame. It hands the frame out one byte at a time over a valid/ready byte stream. A byte-wide UART transmitter downstream can then carry the command to a remote LED pattern controller. Each frame begins with a two-byte sync header. Next come the period bytes, least significant byte first, then the pattern byte, and a single trailer byte closes the frame.

A one-cycle start strobe, sampled while the block is idle, registers both input words. The serializer then raises busy and presents the frame bytes in order. Each byte is held steady until the consumer takes it. Once the trailer is accepted, the block drops busy and issues a one-cycle done pulse. It can accept the next start in that same done cycle, so frames can run back to back with no gap.

Top module: `cmd_frame_serializer`

## Requirements
- R1: A frame is exactly eight bytes, presented in this order: 0x55, 0xA5, period[7:0], period[15:8], period[23:16], period[31:24], pattern[7:0], 0xF0.
- R2: A start strobe seen while idle registers period and pattern at that clock edge. Changes on those inputs afterwards do not alter the frame in progress.
- R3: While tx_valid_o is high and tx_ready_i is low, tx_valid_o stays high and tx_byte_o keeps its value. The frame advances to its next byte only on an edge where valid and ready are both high.
- R4: busy_o rises on the edge that accepts a start and falls on the edge that accepts the trailer byte. tx_valid_o is never high while busy_o is low.
- R5: done_o is high for exactly one cycle, in the cycle right after the trailer byte is accepted, and only then.
- R6: A start strobe seen while busy is ignored and is not remembered. No second frame follows unless start is raised again while idle.
- R7: An active-low asynchronous reset at once clears tx_valid_o, busy_o and done_o. The first frame after reset begins at the 0x55 header byte.
- R8: A start given in the done cycle is accepted, and the 0x55 header is valid in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; its release is synchronised inside |
| start_i | input | 1 | One-cycle request to send a frame |
| period_i | input | 32 | Period word to embed in the frame |
| pattern_i | input | 8 | Pattern word to embed in the frame |
| tx_byte_o | output | 8 | Current frame byte |
| tx_valid_o | output | 1 | tx_byte_o holds a byte to be taken |
| tx_ready_i | input | 1 | Consumer takes the byte on this edge when valid |
| busy_o | output | 1 | A frame is in progress |
| done_o | output | 1 | One-cycle pulse after the trailer byte is taken |

## Verification
The end of one frame and the start of the next can meet in a single cycle. The done pulse for the frame just finished is high in the same cycle that a new start strobe is sampled. The bench provokes this by raising start in exactly the cycle where it sees done high. It judges the result by requiring that, one cycle later, busy and valid are high and the 0x55 header is on the bus for the new words. A second collision is also tested: a start strobe lands on the edge where a middle byte is accepted. That start must leave the byte sequence untouched and must start no second frame.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  localparam byte_t SYNC_HI_DEF = 8'h55;
  localparam byte_t SYNC_LO_DEF = 8'hA5;
  localparam byte_t TRAIL_DEF   = 8'hF0;
endpackage

// File: rtl/cfs_rst_sync.sv
module cfs_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic stage_q, out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_no = out_q;
endmodule

// File: rtl/cfs_capture.sv
module cfs_capture #(
  parameter int unsigned PERIOD_W = 32,
  parameter int unsigned PAT_W    = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic [PAT_W-1:0]    pattern_i,
  output logic [PERIOD_W-1:0] period_q_o,
  output logic [PAT_W-1:0]    pattern_q_o
);
  logic [PERIOD_W-1:0] period_d, period_q;
  logic [PAT_W-1:0]    pattern_d, pattern_q;

  always_comb begin
    period_d  = period_q;
    pattern_d = pattern_q;
    if (load_i) begin
      period_d  = period_i;
      pattern_d = pattern_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q  <= '0;
      pattern_q <= '0;
    end else begin
      period_q  <= period_d;
      pattern_q <= pattern_d;
    end
  end

  assign period_q_o  = period_q;
  assign pattern_q_o = pattern_q;
endmodule

// File: rtl/cfs_seq.sv
module cfs_seq #(
  parameter int unsigned FRAME_LEN = 8,
  localparam int unsigned IDX_W    = $clog2(FRAME_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             ready_i,
  output logic             load_o,
  output logic             busy_o,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  logic             busy_d, busy_q;
  logic             done_d, done_q;
  logic [IDX_W-1:0] idx_d, idx_q;
  logic             take, at_last, load;

  always_comb begin
    load    = start_i && !busy_q;
    take    = busy_q && ready_i;
    at_last = (idx_q == LAST_IDX);
    busy_d  = busy_q;
    idx_d   = idx_q;
    done_d  = 1'b0;
    if (load) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (take) begin
      if (at_last) begin
        busy_d = 1'b0;
        idx_d  = '0;
        done_d = 1'b1;
      end else begin
        idx_d  = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      done_q <= done_d;
    end
  end

  assign load_o  = load;
  assign busy_o  = busy_q;
  assign valid_o = busy_q;
  assign idx_o   = idx_q;
  assign done_o  = done_q;

  assert_hold_idx_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(idx_o)));

  assert_done_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_start_begins_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && idx_o == '0));

  assert_done_after_take_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && ready_i && idx_o == LAST_IDX) |=> (done_o && !busy_o));
endmodule

// File: rtl/cfs_byte_mux.sv
module cfs_byte_mux
  import cfs_pkg::*;
#(
  parameter int unsigned PERIOD_W  = 32,
  parameter byte_t       SYNC_HI   = SYNC_HI_DEF,
  parameter byte_t       SYNC_LO   = SYNC_LO_DEF,
  parameter byte_t       TRAIL     = TRAIL_DEF,
  localparam int unsigned PER_BYTES = PERIOD_W / BYTE_W,
  localparam int unsigned FRAME_LEN = PER_BYTES + 4,
  localparam int unsigned IDX_W     = $clog2(FRAME_LEN)
) (
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  byte_t               pattern_i,
  output byte_t               byte_o
);
  byte_t lanes [FRAME_LEN];

  assign lanes[0] = SYNC_HI;
  assign lanes[1] = SYNC_LO;

  for (genvar g = 0; g < PER_BYTES; g++) begin : g_period_lane
    assign lanes[2+g] = period_i[g*BYTE_W +: BYTE_W];
  end

  assign lanes[FRAME_LEN-2] = pattern_i;
  assign lanes[FRAME_LEN-1] = TRAIL;

  assign byte_o = lanes[idx_i];
endmodule

// File: rtl/cmd_frame_serializer.sv
module cmd_frame_serializer
  import cfs_pkg::*;
#(
  parameter int unsigned PERIOD_W  = 32,
  localparam int unsigned PER_BYTES = PERIOD_W / BYTE_W,
  localparam int unsigned FRAME_LEN = PER_BYTES + 4,
  localparam int unsigned IDX_W     = $clog2(FRAME_LEN)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic [BYTE_W-1:0]   pattern_i,
  output logic [BYTE_W-1:0]   tx_byte_o,
  output logic                tx_valid_o,
  input  logic                tx_ready_i,
  output logic                busy_o,
  output logic                done_o
);
  logic                rst_n;
  logic                load;
  logic [IDX_W-1:0]    idx;
  logic [PERIOD_W-1:0] period_q;
  byte_t               pattern_q;

  cfs_rst_sync u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_n)
  );

  cfs_seq #(.FRAME_LEN(FRAME_LEN)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .start_i(start_i),
    .ready_i(tx_ready_i),
    .load_o (load),
    .busy_o (busy_o),
    .valid_o(tx_valid_o),
    .idx_o  (idx),
    .done_o (done_o)
  );

  cfs_capture #(.PERIOD_W(PERIOD_W), .PAT_W(BYTE_W)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .load_i     (load),
    .period_i   (period_i),
    .pattern_i  (pattern_i),
    .period_q_o (period_q),
    .pattern_q_o(pattern_q)
  );

  cfs_byte_mux #(.PERIOD_W(PERIOD_W)) u_mux (
    .idx_i    (idx),
    .period_i (period_q),
    .pattern_i(pattern_q),
    .byte_o   (tx_byte_o)
  );

  assert_byte_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i) |=> $stable(tx_byte_o));

  assert_busy_start_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(period_q) && $stable(pattern_q)));

  assert_no_valid_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!busy_o) |-> !tx_valid_o);

  assert_header_first_R1: assert property (@(posedge clk_i) disable iff (!rst_n)
    (start_i && !busy_o) |=> (tx_byte_o == SYNC_HI_DEF));
endmodule

// File: tb/cmd_frame_serializer_tb_top.sv
module cmd_frame_serializer_tb_top;
  localparam time CLK_P = 4ns;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        start;
  logic [31:0] period;
  logic [7:0]  pattern;
  logic [7:0]  tx_byte;
  logic        tx_valid;
  logic        tx_ready;
  logic        busy;
  logic        done;

  int n_run  = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  cmd_frame_serializer dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .period_i  (period),
    .pattern_i (pattern),
    .tx_byte_o (tx_byte),
    .tx_valid_o(tx_valid),
    .tx_ready_i(tx_ready),
    .busy_o    (busy),
    .done_o    (done)
  );

  // period, pattern, stall cycles per byte
  localparam logic [41:0] VECS [0:4] = '{
    {32'h1234_5678, 8'hC3, 2'd0},
    {32'h0000_0000, 8'h00, 2'd1},
    {32'hFFFF_FFFF, 8'hFF, 2'd3},
    {32'h0BEB_C200, 8'h5A, 2'd2},
    {32'h8000_0001, 8'h81, 2'd0}
  };

  function automatic logic [7:0] exp_byte(input int i, input logic [31:0] p, input logic [7:0] c);
    case (i)
      0: return 8'h55;
      1: return 8'hA5;
      2: return p[7:0];
      3: return p[15:8];
      4: return p[23:16];
      5: return p[31:24];
      6: return c;
      default: return 8'hF0;
    endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Caller is at a negedge. If skip_start, caller already drove start with per/pat.
  // Returns at the negedge of the done cycle.
  task automatic send(input logic [31:0] per, input logic [7:0] pat, input int stall,
                      input bit poke, input bit skip_start);
    if (!skip_start) begin
      start = 1'b1; period = per; pattern = pat;
    end
    tx_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    period = ~per; pattern = ~pat;   // R2: later input changes must not matter
    chk(busy, 1, "R4 busy after start");
    for (int b = 0; b < 8; b++) begin
      for (int s = 0; s < stall; s++) begin
        chk(tx_valid, 1, "R3 valid held while stalled");
        chk(tx_byte, exp_byte(b, per, pat), "R3 byte held while stalled");
        @(negedge clk);
      end
      chk(tx_byte, exp_byte(b, per, pat), "R1 R2 frame byte");
      chk(tx_valid, 1, "R4 valid during frame");
      tx_ready = 1'b1;
      if (poke && b == 3) start = 1'b1;   // R6 start while busy
      @(negedge clk);
      start = 1'b0;
      tx_ready = 1'b0;
    end
    chk(done, 1, "R5 done after trailer");
    chk(busy, 0, "R4 busy low after trailer");
    chk(tx_valid, 0, "R4 valid low after trailer");
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    #1;
    chk(tx_valid, 0, "R7 valid cleared in reset");
    chk(busy, 0, "R7 busy cleared in reset");
    chk(done, 0, "R7 done cleared in reset");
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    start = 1'b0; period = '0; pattern = '0; tx_ready = 1'b0; rst_ni = 1'b1;
    @(negedge clk);
    do_reset();
    chk(busy, 0, "R7 idle after reset");

    for (int v = 0; v < 5; v++) begin
      send(VECS[v][41:10], VECS[v][9:2], int'(VECS[v][1:0]), 1'b0, 1'b0);
      @(negedge clk);
      chk(done, 0, "R5 done is one cycle");
    end

    // R6: start during a busy frame is dropped
    send(32'hDEAD_BEEF, 8'h3C, 1, 1'b1, 1'b0);
    @(negedge clk);
    chk(done, 0, "R5 done is one cycle");
    chk(busy, 0, "R6 no queued frame");
    @(negedge clk);
    chk(tx_valid, 0, "R6 still idle");

    // R8: start in the done cycle
    send(32'hA1B2_C3D4, 8'h99, 0, 1'b0, 1'b0);
    start = 1'b1; period = 32'h0102_0304; pattern = 8'h77;
    send(32'h0102_0304, 8'h77, 0, 1'b0, 1'b1);
    @(negedge clk);
    chk(done, 0, "R8 done clears after chained frame");

    // R8 first-byte timing checked explicitly
    send(32'h1111_2222, 8'h11, 0, 1'b0, 1'b0);
    start = 1'b1; period = 32'h3333_4444; pattern = 8'h22;
    @(negedge clk);
    start = 1'b0;
    chk(tx_valid, 1, "R8 header valid next cycle");
    chk(tx_byte, 8'h55, "R8 header byte");

    // R7: reset in the middle of a frame
    tx_ready = 1'b1;
    repeat (3) @(negedge clk);
    tx_ready = 1'b0;
    do_reset();
    chk(tx_valid, 0, "R7 idle after mid-frame reset");
    send(32'h5555_AAAA, 8'hE7, 1, 1'b0, 1'b0);
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule